// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is one DMA channel that follows a linked list of command descriptors kept in memory. Software fills in the interrupt enables and the two address step values, clears the status, and then writes the address of the first descriptor into a 64-bit list pointer. The pointer is written as two 32-bit halves. Writing the low half triggers a zero test on the whole pointer, and a non-zero pointer starts the channel on its own.

For each descriptor, the channel first reads the four descriptor words into its working registers. It then copies data one 64-bit beat at a time: a read from the source address, followed by a write to the destination address. After each beat, both addresses advance by their own step values. When a descriptor's data is finished, the channel either fetches the next descriptor or, if that descriptor's link was zero, ends the list.

Completion and fault events set status flags. Software clears these flags by writing ones to them. A single interrupt line reports any set flag whose enable is on. The channel has one memory port with a request/ready handshake, and that port carries both descriptor fetches and data beats.

Top module: `dma_chain_ch`

## Requirements
- R1: A write to register 5 (low pointer half) while idle starts the channel only when {high half, written value} is non-zero; a write to register 6 (high half) never starts it, and a zero pointer leaves the channel idle.
- R2: On start the channel reads the four 64-bit words at pointer+0, +8, +16 and +24 (link, source, destination, byte count) before issuing any data request; the first data request is a read of the descriptor's source address.
- R3: Each beat is a 64-bit read of the source followed by a 64-bit write of the same data to the destination. The beat count is the descriptor byte count with its low 4 bits forced to zero, divided by 8. After each beat the source advances by register 3 and the destination by register 4 (a zero step holds the address). A request stays asserted with a stable address until mem_ready is seen.
- R4: A non-zero link word is loaded into the pointer, and the next descriptor is fetched from it once the current data is done. A zero link leaves the pointer at its previous value and ends the list after that descriptor's data.
- R5: status bit 4 is set each time one descriptor's data completes, and status bit 5 is set when the last descriptor's data completes. Both are set in the cycle busy falls at the end of the list, and bit 4 is set while busy is still high if more descriptors follow.
- R6: A memory error response halts the channel (busy low, no further requests) and writes cause 1 to status bits 3:0. A descriptor whose masked byte count is zero halts it with cause 2 and issues no data requests.
- R7: Writing register 1 clears status bit 4 or 5 where the written bit is one, and clears the cause field when any of written bits 3:0 is one. A new event in the same cycle wins over the clear.
- R8: irq is high one cycle after any of (status bit 4 and ctrl bit 0), (status bit 5 and ctrl bit 1), (non-zero cause and ctrl bit 2) holds. Register 0 is ctrl.
- R9: While busy, writes to registers 2, 3, 4, 5 and 6 (count, source step, destination step, pointer halves) are dropped.
- R10: busy rises in the cycle after the starting write, and after reset busy, status, irq, mem_req and chain_ptr are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select: 0 ctrl, 1 status, 2 count, 3 source step, 4 destination step, 5 pointer low, 6 pointer high |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 64 | Byte address of the request |
| mem_wdata | output | 64 | Write data |
| mem_ready | input | 1 | Request accepted this cycle; read data and error are valid |
| mem_err | input | 1 | Error response for the accepted request |
| mem_rdata | input | 64 | Read data |
| busy | output | 1 | Channel is walking a list |
| status | output | 6 | Bit 5 list end, bit 4 descriptor end, bits 3:0 fault cause |
| chain_ptr | output | 64 | Current list pointer |
| irq | output | 1 | Interrupt request |

## Verification
The assertions take for granted that mem_ready and mem_err only matter in cycles where mem_req is high, and that software issues no register write in the same cycle as reset release. The bench's memory model answers only live requests. It stalls on alternate cycles when stalling is enabled, and it flags an error only at one chosen address. Every descriptor and data region it places lies inside the modelled 4 KiB. The stimulus always clears status before starting a list and writes the pointer high half before the low half, so each start is deliberate.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DESC  = 2'd1,
    ST_READ  = 2'd2,
    ST_WRITE = 2'd3
  } eng_state_e;

  localparam logic [3:0] CAUSE_BUS      = 4'd1;
  localparam logic [3:0] CAUSE_ZERO_LEN = 4'd2;

  localparam logic [2:0] RA_CTRL     = 3'd0;
  localparam logic [2:0] RA_STAT     = 3'd1;
  localparam logic [2:0] RA_COUNT    = 3'd2;
  localparam logic [2:0] RA_SRC_STEP = 3'd3;
  localparam logic [2:0] RA_DST_STEP = 3'd4;
  localparam logic [2:0] RA_PTR_LO   = 3'd5;
  localparam logic [2:0] RA_PTR_HI   = 3'd6;
endpackage

// File: rtl/dma_chain_engine.sv
module dma_chain_engine import dma_chain_pkg::*; #(
  parameter int ADDR_W   = 64,
  parameter int DATA_W   = 64,
  parameter int CNT_W    = 32,
  parameter int STEP_W   = 32,
  parameter int RSV_BITS = 4,
  parameter int REG_W    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic              mem_err,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic [ADDR_W-1:0] chain_ptr,
  output logic              done_xfer,
  output logic              done_chain,
  output logic              fault,
  output logic [3:0]        fault_cause
);
  localparam int BEAT_BYTES = DATA_W / 8;
  localparam int WORD_SH    = $clog2(BEAT_BYTES);

  eng_state_e        state_q;
  logic [1:0]        widx_q;
  logic [ADDR_W-1:0] base_q, chain_q, src_q, dst_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [STEP_W-1:0] sstep_q, dstep_q;
  logic [DATA_W-1:0] hold_q;
  logic              last_q;

  logic              idle, accept, start, len_zero;
  logic [ADDR_W-1:0] start_ptr, link_word;
  logic [CNT_W-1:0]  len_word;

  assign idle      = (state_q == ST_IDLE);
  assign accept    = mem_req && mem_ready;
  assign start_ptr = {chain_q[ADDR_W-1:REG_W], reg_wdata};
  assign start     = idle && reg_we && (reg_addr == RA_PTR_LO) && (start_ptr != '0);
  assign link_word = mem_rdata[ADDR_W-1:0];
  // reserved low bits of the count word are forced to zero
  assign len_word  = {mem_rdata[CNT_W-1:RSV_BITS], {RSV_BITS{1'b0}}};
  assign len_zero  = (state_q == ST_DESC) && (widx_q == 2'd3) && (len_word == '0);

  always_comb begin
    mem_req   = !idle;
    mem_we    = (state_q == ST_WRITE);
    mem_wdata = hold_q;
    case (state_q)
      ST_DESC:  mem_addr = base_q + (ADDR_W'(widx_q) << WORD_SH);
      ST_WRITE: mem_addr = dst_q;
      default:  mem_addr = src_q;
    endcase
  end

  assign fault       = accept && (mem_err || len_zero);
  assign fault_cause = mem_err ? CAUSE_BUS : CAUSE_ZERO_LEN;
  assign done_xfer   = accept && !mem_err && (state_q == ST_WRITE) &&
                       (cnt_q == CNT_W'(BEAT_BYTES));
  assign done_chain  = done_xfer && last_q;
  assign busy        = !idle;
  assign chain_ptr   = chain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      widx_q  <= '0;
      base_q  <= '0;
      chain_q <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      cnt_q   <= '0;
      sstep_q <= '0;
      dstep_q <= '0;
      hold_q  <= '0;
      last_q  <= 1'b0;
    end else begin
      // software access to working registers only while idle
      if (idle && reg_we) begin
        case (reg_addr)
          RA_COUNT:    cnt_q <= CNT_W'(reg_wdata);
          RA_SRC_STEP: sstep_q <= STEP_W'(reg_wdata);
          RA_DST_STEP: dstep_q <= STEP_W'(reg_wdata);
          RA_PTR_LO:   chain_q[REG_W-1:0] <= reg_wdata;
          RA_PTR_HI:   chain_q[ADDR_W-1:REG_W] <= reg_wdata;
          default: ;
        endcase
      end
      if (start) begin
        state_q <= ST_DESC;
        widx_q  <= '0;
        base_q  <= start_ptr;
      end
      if (accept) begin
        if (fault) begin
          state_q <= ST_IDLE;
        end else begin
          case (state_q)
            ST_DESC: begin
              widx_q <= widx_q + 2'd1;
              case (widx_q)
                2'd0: begin
                  last_q <= (link_word == '0);
                  if (link_word != '0) chain_q <= link_word;
                end
                2'd1: src_q <= mem_rdata[ADDR_W-1:0];
                2'd2: dst_q <= mem_rdata[ADDR_W-1:0];
                default: begin
                  cnt_q   <= len_word;
                  state_q <= ST_READ;
                end
              endcase
            end
            ST_READ: begin
              hold_q  <= mem_rdata;
              state_q <= ST_WRITE;
            end
            ST_WRITE: begin
              src_q <= src_q + ADDR_W'(sstep_q);
              dst_q <= dst_q + ADDR_W'(dstep_q);
              cnt_q <= cnt_q - CNT_W'(BEAT_BYTES);
              if (done_xfer) begin
                if (last_q) begin
                  state_q <= ST_IDLE;
                end else begin
                  state_q <= ST_DESC;
                  widx_q  <= '0;
                  base_q  <= chain_q;
                end
              end else begin
                state_q <= ST_READ;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/dma_chain_csr.sv
module dma_chain_csr import dma_chain_pkg::*; (
  input  logic       clk,
  input  logic       rst,
  input  logic       reg_we,
  input  logic [2:0] reg_addr,
  input  logic [5:0] wbits,
  input  logic       done_xfer,
  input  logic       done_chain,
  input  logic       fault,
  input  logic [3:0] fault_cause,
  output logic [5:0] status,
  output logic       irq
);
  logic [2:0] ctrl_q;
  logic [3:0] cause_q;
  logic       xfer_q, list_q, irq_q;
  logic       ctrl_wr, stat_wr;

  assign ctrl_wr = reg_we && (reg_addr == RA_CTRL);
  assign stat_wr = reg_we && (reg_addr == RA_STAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      cause_q <= '0;
      xfer_q  <= 1'b0;
      list_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= wbits[2:0];
      // a new event wins over a clear in the same cycle
      if (fault) cause_q <= fault_cause;
      else if (stat_wr && (wbits[3:0] != 4'd0)) cause_q <= '0;
      if (done_xfer) xfer_q <= 1'b1;
      else if (stat_wr && wbits[4]) xfer_q <= 1'b0;
      if (done_chain) list_q <= 1'b1;
      else if (stat_wr && wbits[5]) list_q <= 1'b0;
      irq_q <= (xfer_q & ctrl_q[0]) | (list_q & ctrl_q[1]) |
               ((cause_q != 4'd0) & ctrl_q[2]);
    end
  end

  assign status = {list_q, xfer_q, cause_q};
  assign irq    = irq_q;
endmodule

// File: rtl/dma_chain_ch.sv
module dma_chain_ch #(
  parameter int ADDR_W   = 64,
  parameter int DATA_W   = 64,
  parameter int CNT_W    = 32,
  parameter int STEP_W   = 32,
  parameter int RSV_BITS = 4,
  localparam int REG_W   = ADDR_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic              mem_err,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic [5:0]        status,
  output logic [ADDR_W-1:0] chain_ptr,
  output logic              irq
);
  logic       done_xfer, done_chain, fault;
  logic [3:0] fault_cause;

  dma_chain_engine #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .STEP_W(STEP_W), .RSV_BITS(RSV_BITS), .REG_W(REG_W)
  ) u_engine (
    .clk(clk), .rst(rst),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .busy(busy), .chain_ptr(chain_ptr),
    .done_xfer(done_xfer), .done_chain(done_chain),
    .fault(fault), .fault_cause(fault_cause)
  );

  dma_chain_csr u_csr (
    .clk(clk), .rst(rst),
    .reg_we(reg_we), .reg_addr(reg_addr), .wbits(reg_wdata[5:0]),
    .done_xfer(done_xfer), .done_chain(done_chain),
    .fault(fault), .fault_cause(fault_cause),
    .status(status), .irq(irq)
  );
endmodule

// File: rtl/dma_chain_chk.sv
module dma_chain_chk #(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic [2:0]        reg_addr,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              busy,
  input logic [5:0]        status,
  input logic [ADDR_W-1:0] chain_ptr,
  input logic              irq
);
  assert_start_from_low_write_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(reg_we && (reg_addr == 3'd5)));

  assert_request_held_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_pointer_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(busy) && !$past(reg_we)) |-> $stable(chain_ptr));

  assert_list_end_at_stop_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(status[5]) |-> ($past(busy) && !busy));

  assert_fault_halts_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(status[3:0] != 4'd0) |-> !busy);

  assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(status != 6'd0));
endmodule

bind dma_chain_ch dma_chain_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ready(mem_ready), .mem_addr(mem_addr),
  .busy(busy), .status(status), .chain_ptr(chain_ptr), .irq(irq)
);

// File: tb/dma_chain_ch_tb.sv
module dma_chain_ch_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        mem_req, mem_we, mem_ready, mem_err;
  logic [63:0] mem_addr, mem_wdata, mem_rdata, chain_ptr;
  logic        busy, irq;
  logic [5:0]  status;

  logic [63:0] mem     [0:511];
  logic [63:0] ref_mem [0:511];
  logic [63:0] log_a   [0:63];
  logic        log_w   [0:63];
  int          log_n = 0;
  logic        init_req = 1'b0, poke_en = 1'b0, log_clr = 1'b0;
  logic [8:0]  poke_idx = '0;
  logic [63:0] poke_dat = '0;
  logic        stall_en = 1'b0, stall_q = 1'b0, err_en = 1'b0;
  logic [63:0] err_addr = '0;
  int          checks = 0, fails = 0;

  // src, dst, byte count, source step, destination step
  localparam logic [63:0] VECS [4] = '{
    {16'h0000, 16'h0800, 16'h0020, 8'd8,  8'd8},
    {16'h0100, 16'h0900, 16'h002F, 8'd8,  8'd8},
    {16'h0040, 16'h0A00, 16'h0030, 8'd0,  8'd8},
    {16'h0200, 16'h0B00, 16'h0010, 8'd16, 8'd0}
  };

  always #2 clk = ~clk;

  dma_chain_ch u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .busy(busy), .status(status), .chain_ptr(chain_ptr), .irq(irq)
  );

  function automatic logic [63:0] pat(int i);
    return {16'hC0DE, 16'(i), 32'(i * 32'h9E37)};
  endfunction

  assign mem_ready = mem_req && !(stall_en && stall_q);
  assign mem_rdata = mem[mem_addr[11:3]];
  assign mem_err   = mem_req && err_en && (mem_addr == err_addr);

  always @(posedge clk) begin
    stall_q <= ~stall_q;
    if (init_req) begin
      for (int i = 0; i < 512; i++) mem[i] <= pat(i);
    end else if (poke_en) begin
      mem[poke_idx] <= poke_dat;
    end else if (mem_req && mem_ready && mem_we && !mem_err) begin
      mem[mem_addr[11:3]] <= mem_wdata;
    end
    if (log_clr) log_n <= 0;
    else if (mem_req && mem_ready && log_n < 64) begin
      log_a[log_n] <= mem_addr;
      log_w[log_n] <= mem_we;
      log_n <= log_n + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic poke(input int idx, input logic [63:0] d);
    poke_en = 1'b1; poke_idx = 9'(idx); poke_dat = d;
    ref_mem[idx] = d;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  task automatic mem_init();
    init_req = 1'b1;
    for (int i = 0; i < 512; i++) ref_mem[i] = pat(i);
    @(negedge clk);
    init_req = 1'b0;
  endtask

  task automatic put_desc(input int base, input logic [63:0] nxt, input logic [63:0] s,
                          input logic [63:0] d, input logic [63:0] n);
    poke(base / 8, nxt);
    poke(base / 8 + 1, s);
    poke(base / 8 + 2, d);
    poke(base / 8 + 3, n);
  endtask

  task automatic ref_copy(input int s, input int d, input int n, input int ss, input int ds);
    for (int k = 0; k < (n & 32'hFFF0) / 8; k++)
      ref_mem[((d + k * ds) >> 3) & 511] = ref_mem[((s + k * ss) >> 3) & 511];
  endtask

  task automatic clear_log();
    log_clr = 1'b1;
    @(negedge clk);
    log_clr = 1'b0;
  endtask

  task automatic go(input logic [63:0] p);
    wr(3'd6, p[63:32]);
    wr(3'd5, p[31:0]);
  endtask

  task automatic wait_idle(input string tag);
    for (int k = 0; k < 4000; k++) begin
      if (!busy) break;
      @(negedge clk);
    end
    check(!busy, tag, 64'(busy), 64'd0);
  endtask

  task automatic mem_check(input string tag);
    int bad = -1;
    for (int i = 0; i < 512; i++)
      if (mem[i] !== ref_mem[i] && bad < 0) bad = i;
    if (bad < 0) check(1'b1, tag, 64'd0, 64'd0);
    else check(1'b0, tag, mem[bad], ref_mem[bad]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=%h expected=%h", 64'd1, 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    cyc(5);
    rst = 1'b0;
    cyc(1);
    // R10 reset state
    check(!busy && !mem_req && !irq, "R10 reset busy/req/irq", {busy, mem_req, irq}, 64'd0);
    check(status == 6'd0, "R10 reset status", 64'(status), 64'd0);
    check(chain_ptr == 64'd0, "R10 reset pointer", chain_ptr, 64'd0);

    // R1 high-half write alone, and a zero pointer, never start
    wr(3'd6, 32'h1);
    cyc(2);
    check(!busy, "R1 high half no start", 64'(busy), 64'd0);
    check(chain_ptr == 64'h1_0000_0000, "R1 high half stored", chain_ptr, 64'h1_0000_0000);
    wr(3'd6, 32'h0);
    wr(3'd5, 32'h0);
    cyc(2);
    check(!busy, "R1 zero pointer no start", 64'(busy), 64'd0);

    // vector table: single-descriptor copies (R2, R3, R4, R5, R8)
    for (int v = 0; v < 4; v++) begin
      automatic logic [63:0] vec = VECS[v];
      automatic int s  = int'(vec[63:48]);
      automatic int d  = int'(vec[47:32]);
      automatic int n  = int'(vec[31:16]);
      automatic int ss = int'(vec[15:8]);
      automatic int ds = int'(vec[7:0]);
      automatic int beats = (n & 32'hFFF0) / 8;
      mem_init();
      put_desc(32'hE00, 64'd0, 64'(s), 64'(d), 64'(n));
      wr(3'd3, 32'(ss));
      wr(3'd4, 32'(ds));
      wr(3'd2, 32'd0);
      wr(3'd1, 32'h3F);
      clear_log();
      go(64'hE00);
      if (v == 0) check(busy, "R10 busy after start", 64'(busy), 64'd1);
      wait_idle("R3 vector completes");
      ref_copy(s, d, n, ss, ds);
      mem_check("R3 vector memory");
      check(status == 6'h30, "R5 vector status", 64'(status), 64'h30);
      check(chain_ptr == 64'hE00, "R4 zero link keeps pointer", chain_ptr, 64'hE00);
      check(log_n == 4 + 2 * beats, "R3 request count", 64'(log_n), 64'(4 + 2 * beats));
      check(!irq, "R8 irq gated off", 64'(irq), 64'd0);
      if (v == 0) begin
        for (int k = 0; k < 4; k++)
          check(log_a[k] == 64'(32'hE00 + 8 * k) && !log_w[k], "R2 descriptor fetch order",
                log_a[k], 64'(32'hE00 + 8 * k));
        check(log_a[4] == 64'(s) && !log_w[4], "R2 first data read", log_a[4], 64'(s));
        check(log_a[5] == 64'(d) && log_w[5], "R3 first data write", log_a[5], 64'(d));
      end
    end

    // R4 R5 three-descriptor list
    mem_init();
    put_desc(32'hE00, 64'hE40, 64'h000, 64'h800, 64'h10);
    put_desc(32'hE40, 64'hE80, 64'h100, 64'h900, 64'h10);
    put_desc(32'hE80, 64'd0,   64'h200, 64'hA00, 64'h10);
    wr(3'd3, 32'd8);
    wr(3'd4, 32'd8);
    wr(3'd1, 32'h3F);
    clear_log();
    go(64'hE00);
    for (int k = 0; k < 200; k++) begin
      if (status[4]) break;
      @(negedge clk);
    end
    check(status[4] && busy && !status[5], "R5 descriptor end mid-list",
          {busy, status}, {1'b1, 6'h10});
    wait_idle("R4 list completes");
    ref_copy(32'h000, 32'h800, 32'h10, 8, 8);
    ref_copy(32'h100, 32'h900, 32'h10, 8, 8);
    ref_copy(32'h200, 32'hA00, 32'h10, 8, 8);
    mem_check("R4 list memory");
    check(status == 6'h30, "R5 list status", 64'(status), 64'h30);
    check(chain_ptr == 64'hE80, "R4 pointer holds last link", chain_ptr, 64'hE80);
    check(log_a[8] == 64'hE40, "R4 second fetch from link", log_a[8], 64'hE40);
    check(log_a[16] == 64'hE80, "R4 third fetch from link", log_a[16], 64'hE80);
    check(log_n == 24, "R4 list request count", 64'(log_n), 64'd24);

    // R7 R8 interrupt gating and write-one-to-clear
    check(!irq, "R8 irq off with enables clear", 64'(irq), 64'd0);
    wr(3'd0, 32'h2);
    cyc(2);
    check(irq, "R8 list-end enable", 64'(irq), 64'd1);
    wr(3'd1, 32'h20);
    cyc(2);
    check(status == 6'h10, "R7 clear list-end only", 64'(status), 64'h10);
    check(!irq, "R8 irq drops after clear", 64'(irq), 64'd0);
    wr(3'd0, 32'h1);
    cyc(2);
    check(irq, "R8 descriptor-end enable", 64'(irq), 64'd1);
    wr(3'd1, 32'h10);
    cyc(2);
    check(status == 6'h00 && !irq, "R7 clear descriptor-end", {irq, status}, 64'd0);
    wr(3'd0, 32'h0);

    // R6 bus error on second source read
    mem_init();
    put_desc(32'hE00, 64'd0, 64'h000, 64'h800, 64'h20);
    err_en = 1'b1;
    err_addr = 64'h008;
    clear_log();
    go(64'hE00);
    wait_idle("R6 halt on error");
    ref_mem[32'h800 >> 3] = ref_mem[0];
    mem_check("R6 error memory");
    check(status == 6'h01, "R6 cause bus error", 64'(status), 64'h01);
    check(log_n == 7, "R6 no requests after error", 64'(log_n), 64'd7);
    check(!irq, "R8 error irq gated", 64'(irq), 64'd0);
    wr(3'd0, 32'h4);
    cyc(2);
    check(irq, "R8 error enable", 64'(irq), 64'd1);
    wr(3'd1, 32'h1);
    cyc(2);
    check(status == 6'h00 && !irq, "R7 clear cause", {irq, status}, 64'd0);
    wr(3'd0, 32'h0);
    err_en = 1'b0;

    // R6 zero length after masking
    mem_init();
    put_desc(32'hE00, 64'd0, 64'h000, 64'h800, 64'h0F);
    clear_log();
    go(64'hE00);
    wait_idle("R6 halt on zero length");
    mem_check("R6 zero length memory");
    check(status == 6'h02, "R6 cause zero length", 64'(status), 64'h02);
    check(log_n == 4, "R6 no data requests", 64'(log_n), 64'd4);
    wr(3'd1, 32'h3F);

    // R9 writes while busy dropped, R3 with stalls
    stall_en = 1'b1;
    mem_init();
    put_desc(32'hE00, 64'd0, 64'h000, 64'h800, 64'h40);
    wr(3'd3, 32'd8);
    wr(3'd4, 32'd8);
    go(64'hE00);
    wr(3'd6, 32'h55);
    wr(3'd3, 32'd0);
    wr(3'd2, 32'h10);
    wait_idle("R9 stalled transfer completes");
    ref_copy(32'h000, 32'h800, 32'h40, 8, 8);
    mem_check("R9 steps unchanged while busy");
    check(chain_ptr == 64'hE00, "R9 pointer write dropped", chain_ptr, 64'hE00);
    check(status == 6'h30, "R3 stalled status", 64'(status), 64'h30);
    stall_en = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule